// File: doc/BRIEF.md
# Register-Sequence Unlock Timing Controller

This block watches the host side of a legacy task-file register bus and keeps a hidden set of per-drive PIO timing fields. These fields are not reached by plain address decode. They open only after software issues an exact, ordered series of task-file and control-space accesses. Once that series completes, the block enters an unlocked state. It shows this to software by clearing bit 7 of the sector-count register when it is read back.

While unlocked, a write to the timing offset loads a staging copy of the packed fields. A sector-count write with bit 0 set moves the staged copy into the live fields that drive `timing_out`. A read of offset 5 then locks the block again. Separately, the block notices a burst of sector-count reads and arms the data port for 32-bit transfers. It supplies read data only for the registers it owns and flags those cycles on `bus_rdata_own`.

Top module: `reg_unlock_timing`

## Requirements
- R1: After reset the block is locked, `timing_out` is 0, `wide_armed` is 0 and the sector-count shadow reads as 0x00.
- R2: The block unlocks after this exact sequence of single accesses: read offset 5; write offset 2 with bit 7 = 1; read offset 2; two reads in control space (`bus_alt`=1, address ignored); two reads of offset 2. `unlocked` rises on the clock edge that takes the last read.
- R3: A task-file read of offset 2 returns the last value written there, with `bus_rdata_own`=1. Bit 7 reads as 0 while unlocked and as the written bit while locked.
- R4: While locked, any access that does not match the next expected step sends the detector back to its first step. That access is not counted as the first step of a new attempt, so a fresh full sequence is still needed, and that fresh sequence unlocks.
- R5: A sector-count write with bit 7 = 0 in place of the second step does not advance the sequence.
- R6: While unlocked, a write to offset 3 loads its low 6 bits into the staging copy without changing `timing_out`. A write to offset 2 with bit 0 = 1 copies the staging value into `timing_out` on that edge. A write to offset 2 with bit 0 = 0 commits nothing.
- R7: Drive d owns bits [3d+2:3d] of `timing_out`. The field code for PIO mode n is 0 for n = 0 and 1 + 3n otherwise, which gives 0, 4 and 7 for modes 0 to 2.
- R8: While unlocked, a read of offset 5 locks the block on that edge, and `timing_out` keeps its value.
- R9: While locked, writes to offset 3 and sector-count writes with bit 0 set leave `timing_out` unchanged.
- R10: Three consecutive task-file reads of offset 2 set `wide_armed`. Data-port accesses (offset 0) keep it set. Any other access clears it, and any other access also restarts the count before arming.
- R11: A read of offset 3 while unlocked returns the staging value, zero-extended, with `bus_rdata_own`=1. Unlocking loads the staging copy from `timing_out`. While locked, offset 3 is not owned (`bus_rdata_own`=0, data 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | One access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_alt | input | 1 | 1 = control-block space, 0 = task-file space |
| bus_addr | input | 3 | Register offset inside the selected space |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for owned registers |
| bus_rdata_own | output | 1 | Block supplies `bus_rdata` this cycle |
| unlocked | output | 1 | Timing access open |
| timing_out | output | 6 | Packed per-drive timing fields |
| wide_armed | output | 1 | Data port set up for 32-bit transfers |

## Verification
On every cycle the assertions check five things. Live timing moves only on an unlocked commit write. A sector-count read never shows bit 7 while unlocked. An offset-5 read relocks. Unlocking happens only on a sector-count read, and arming happens only on a sector-count read. The ordering rules need the bench's scenarios: the exact order of the sequence, the break at every step by four kinds of wrong access, the rule that a restart read is not counted, the field codes for every pair of drive modes, and the exact count of reads needed to arm.

// File: rtl/ulk_pkg.sv
// Shared types for the unlock timing controller.
// Assumes: the task-file and control spaces are told apart by one select bit.
package ulk_pkg;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_SECT = 3'd2;
    localparam logic [2:0] OFS_TIME = 3'd3;
    localparam logic [2:0] OFS_KEY  = 3'd5;

    // Kind of access seen this cycle, as the detectors need it
    typedef enum logic [2:0] {
        AK_IDLE,
        AK_RD_KEY,
        AK_WR_SC_SET7,
        AK_WR_SC,
        AK_RD_SC,
        AK_RD_ALT,
        AK_DATA,
        AK_OTHER
    } acc_kind_e;

    localparam int SEQ_LEN = 7;

    // Expected access kind for each step of the unlock sequence
    function automatic acc_kind_e step_kind(input logic [2:0] s);
        case (s)
            3'd0:    return AK_RD_KEY;
            3'd1:    return AK_WR_SC_SET7;
            3'd2:    return AK_RD_SC;
            3'd3:    return AK_RD_ALT;
            3'd4:    return AK_RD_ALT;
            3'd5:    return AK_RD_SC;
            default: return AK_RD_SC;
        endcase
    endfunction

endpackage

// File: rtl/unlock_seq_det.sv
// Ordered-sequence detector for the unlock pattern.
// Each step must match exactly. A mismatch returns to step 0 and is not
// counted as a new step 0. The detector holds while the block is unlocked.
module unlock_seq_det
    import ulk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  acc_kind_e kind,
    input  logic      hold,
    output logic      done
);
    localparam logic [2:0] LAST = 3'(SEQ_LEN - 1);

    logic [2:0] step;
    logic       live;
    logic       hit;

    // Decode whether this cycle's access matches the awaited step
    always_comb begin
        live = (kind != AK_IDLE) && !hold;
        hit  = live && (kind == step_kind(step));
        done = hit && (step == LAST);
    end

    // Advance on a match, fall back to step 0 on anything else
    always_ff @(posedge clk) begin
        if (!rst_n)
            step <= '0;
        else if (live)
            step <= (hit && step != LAST) ? step + 3'd1 : 3'd0;
    end

endmodule

// File: rtl/timing_bank.sv
// Per-drive timing fields, each with a staging copy and a live copy.
// Assumes: reload, stage_we and commit never come in the same cycle.
module timing_bank #(
    parameter int NUM_DRIVES = 2,
    parameter int FIELD_W    = 3,
    localparam int TW        = NUM_DRIVES * FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic          stage_we,
    input  logic [TW-1:0] stage_val,
    input  logic          commit,
    output logic [TW-1:0] staged,
    output logic [TW-1:0] live
);
    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
        logic [FIELD_W-1:0] stg_q;
        logic [FIELD_W-1:0] live_q;

        // Staging copy: reloaded on unlock, written by software
        always_ff @(posedge clk) begin
            if (!rst_n)
                stg_q <= '0;
            else if (reload)
                stg_q <= live_q;
            else if (stage_we)
                stg_q <= stage_val[d*FIELD_W +: FIELD_W];
        end

        // Live copy: takes the staging copy on commit
        always_ff @(posedge clk) begin
            if (!rst_n)
                live_q <= '0;
            else if (commit)
                live_q <= stg_q;
        end

        assign staged[d*FIELD_W +: FIELD_W] = stg_q;
        assign live[d*FIELD_W +: FIELD_W]   = live_q;
    end

endmodule

// File: rtl/wide_arm_det.sv
// Counts back-to-back sector-count reads and arms 32-bit data transfers.
// Data-port accesses keep the armed state. Other accesses clear it.
module wide_arm_det
    import ulk_pkg::*;
#(
    parameter int ARM_READS = 3,
    localparam int CW       = $clog2(ARM_READS + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  acc_kind_e kind,
    output logic      armed
);
    localparam logic [CW-1:0] FULL = CW'(ARM_READS);

    logic [CW-1:0] cnt;

    assign armed = (cnt == FULL);

    // Saturating run-length counter of consecutive sector-count reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else begin
            case (kind)
                AK_IDLE:  cnt <= cnt;
                AK_RD_SC: cnt <= armed ? cnt : cnt + 1'b1;
                AK_DATA:  cnt <= armed ? cnt : '0;
                default:  cnt <= '0;
            endcase
        end
    end

endmodule

// File: rtl/reg_unlock_timing.sv
// Top: decodes bus accesses, keeps the lock state and the sector-count
// shadow, and returns read data for the registers it owns.
// Assumes: at most one access per cycle; the packed timing width fits a byte.
module reg_unlock_timing
    import ulk_pkg::*;
#(
    parameter int NUM_DRIVES = 2,
    parameter int FIELD_W    = 3,
    parameter int ARM_READS  = 3,
    localparam int TW        = NUM_DRIVES * FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic          bus_alt,
    input  logic [2:0]    bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    output logic          bus_rdata_own,
    output logic          unlocked,
    output logic [TW-1:0] timing_out,
    output logic          wide_armed
);
    acc_kind_e     kind;
    logic          seq_done;
    logic          tf_rd;
    logic          tf_wr;
    logic          stage_we;
    logic          commit;
    logic [7:0]    sc_q;
    logic [TW-1:0] staged;

    // Classify this cycle's access
    always_comb begin
        tf_rd = bus_valid && !bus_write && !bus_alt;
        tf_wr = bus_valid &&  bus_write && !bus_alt;
        if (!bus_valid)
            kind = AK_IDLE;
        else if (bus_alt)
            kind = bus_write ? AK_OTHER : AK_RD_ALT;
        else begin
            case (bus_addr)
                OFS_DATA: kind = AK_DATA;
                OFS_SECT: kind = !bus_write ? AK_RD_SC
                               : (bus_wdata[7] ? AK_WR_SC_SET7 : AK_WR_SC);
                OFS_KEY:  kind = bus_write ? AK_OTHER : AK_RD_KEY;
                default:  kind = AK_OTHER;
            endcase
        end
    end

    // Timing write strobes are honoured only while unlocked
    always_comb begin
        stage_we = unlocked && tf_wr && (bus_addr == OFS_TIME);
        commit   = unlocked && tf_wr && (bus_addr == OFS_SECT) && bus_wdata[0];
    end

    unlock_seq_det u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .hold  (unlocked),
        .done  (seq_done)
    );

    timing_bank #(
        .NUM_DRIVES (NUM_DRIVES),
        .FIELD_W    (FIELD_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (seq_done),
        .stage_we  (stage_we),
        .stage_val (bus_wdata[TW-1:0]),
        .commit    (commit),
        .staged    (staged),
        .live      (timing_out)
    );

    wide_arm_det #(
        .ARM_READS (ARM_READS)
    ) u_wide (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .armed (wide_armed)
    );

    // Lock state: opened by the full sequence, closed by a key-offset read
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlocked <= 1'b0;
        else if (seq_done)
            unlocked <= 1'b1;
        else if (unlocked && kind == AK_RD_KEY)
            unlocked <= 1'b0;
    end

    // Sector-count shadow register
    always_ff @(posedge clk) begin
        if (!rst_n)
            sc_q <= '0;
        else if (tf_wr && bus_addr == OFS_SECT)
            sc_q <= bus_wdata;
    end

    // Read data for owned registers; bit 7 of sector count shows lock state
    always_comb begin
        bus_rdata     = '0;
        bus_rdata_own = 1'b0;
        if (tf_rd && bus_addr == OFS_SECT) begin
            bus_rdata     = {sc_q[7] && !unlocked, sc_q[6:0]};
            bus_rdata_own = 1'b1;
        end else if (tf_rd && unlocked && bus_addr == OFS_TIME) begin
            bus_rdata[TW-1:0] = staged;
            bus_rdata_own     = 1'b1;
        end
    end

endmodule

// File: rtl/ulk_checker.sv
// Cycle-level properties of the unlock timing controller, bound to the top.
// Assumes: the bound top uses the offsets from ulk_pkg.
module ulk_checker #(
    parameter int TW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_valid,
    input logic          bus_write,
    input logic          bus_alt,
    input logic [2:0]    bus_addr,
    input logic          wbit0,
    input logic          rbit7,
    input logic          bus_rdata_own,
    input logic          unlocked,
    input logic [TW-1:0] timing_out,
    input logic          wide_armed
);
    logic past_ok;
    logic rd_sc;
    logic rd_key;
    logic wr_commit;

    // One cycle of history after reset before any $past is trusted
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign rd_sc     = bus_valid && !bus_write && !bus_alt && bus_addr == 3'd2;
    assign rd_key    = bus_valid && !bus_write && !bus_alt && bus_addr == 3'd5;
    assign wr_commit = bus_valid &&  bus_write && !bus_alt && bus_addr == 3'd2 && wbit0;

    assert_locked_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(unlocked) |-> $stable(timing_out));

    assert_commit_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(unlocked) && !$past(wr_commit) |-> $stable(timing_out));

    assert_bit7_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked && rd_sc |-> bus_rdata_own && !rbit7);

    assert_relock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(unlocked && rd_key) |-> !unlocked);

    assert_unlock_on_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $rose(unlocked) |-> $past(rd_sc));

    assert_arm_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $rose(wide_armed) |-> $past(rd_sc));

endmodule

bind reg_unlock_timing ulk_checker #(.TW(TW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_alt       (bus_alt),
    .bus_addr      (bus_addr),
    .wbit0         (bus_wdata[0]),
    .rbit7         (bus_rdata[7]),
    .bus_rdata_own (bus_rdata_own),
    .unlocked      (unlocked),
    .timing_out    (timing_out),
    .wide_armed    (wide_armed)
);

// File: tb/reg_unlock_timing_tb_top.sv
// Sweep bench: breaks the unlock sequence at every step, walks all mode
// pairs through the timing fields and sweeps the arming read count.
module reg_unlock_timing_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0;
    logic       bus_write = 1'b0;
    logic       bus_alt = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rdata_own;
    logic       unlocked;
    logic [5:0] timing_out;
    logic       wide_armed;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    reg_unlock_timing dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_alt(bus_alt), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdata_own(bus_rdata_own), .unlocked(unlocked),
        .timing_out(timing_out), .wide_armed(wide_armed)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] code(input int n);
        return (n == 0) ? 3'd0 : 3'(1 + 3 * n);
    endfunction

    task automatic wr(input bit alt, input logic [2:0] a, input logic [7:0] d);
        bus_valid = 1; bus_write = 1; bus_alt = alt; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input bit alt, input logic [2:0] a, output logic [7:0] v, output logic own);
        bus_valid = 1; bus_write = 0; bus_alt = alt; bus_addr = a;
        #1;
        v = bus_rdata; own = bus_rdata_own;
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic steps(input int from, input int to, input logic [6:0] lo);
        logic [7:0] v; logic o;
        for (int s = from; s < to; s++) begin
            case (s)
                0: rd(0, 3'd5, v, o);
                1: wr(0, 3'd2, {1'b1, lo});
                2: begin rd(0, 3'd2, v, o); chk("R3", "locked sc read", {o, v}, {1'b1, 1'b1, lo}); end
                3, 4: rd(1, 3'd6, v, o);
                default: rd(0, 3'd2, v, o);
            endcase
        end
    endtask

    initial begin
        logic [7:0] v; logic o;
        logic [5:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1", "unlocked", unlocked, 0);
        chk("R1", "timing", timing_out, 0);
        chk("R1", "wide", wide_armed, 0);
        rd(0, 3'd2, v, o);
        chk("R1", "sc reset value", {o, v}, {1'b1, 8'h00});

        // R4 R5: break at every step with four kinds of wrong access
        for (int k = 1; k <= 6; k++) begin
            for (int kind = 0; kind < 4; kind++) begin
                logic [6:0] lo;
                lo = 7'(k * 16 + kind);
                steps(0, k, lo);
                case (kind)
                    0: wr(1, 3'd6, 8'h00);
                    1: wr(0, 3'd7, 8'hEC);
                    2: rd(0, 3'd5, v, o);
                    default: wr(0, 3'd2, {1'b0, lo});
                endcase
                if (kind == 2) steps(1, 7, lo);
                chk(kind == 3 ? "R5" : "R4", "stays locked after break", unlocked, 0);
                steps(0, 7, lo);
                chk("R2", "unlock after full sequence", unlocked, 1);
                rd(0, 3'd2, v, o);
                chk("R3", "unlocked sc read", {o, v}, {1'b1, 1'b0, lo});
                rd(0, 3'd5, v, o);
                chk("R8", "relock", unlocked, 0);
            end
        end

        // R6 R7 R11: every pair of drive modes
        steps(0, 7, 7'h11);
        prev = 6'd0;
        for (int m0 = 0; m0 < 3; m0++) begin
            for (int m1 = 0; m1 < 3; m1++) begin
                logic [5:0] val;
                val = {code(m1), code(m0)};
                wr(0, 3'd3, {2'b00, val});
                chk("R6", "staged not live", timing_out, prev);
                rd(0, 3'd3, v, o);
                chk("R11", "staged readback", {o, v}, {1'b1, 2'b00, val});
                wr(0, 3'd2, 8'h00);
                chk("R6", "bit0 clear no commit", timing_out, prev);
                wr(0, 3'd2, 8'h01);
                chk("R7", "drive0 field", timing_out[2:0], code(m0));
                chk("R7", "drive1 field", timing_out[5:3], code(m1));
                prev = val;
            end
        end
        wr(0, 3'd3, 8'h04);
        rd(0, 3'd5, v, o);
        chk("R8", "relock keeps timing", {unlocked, timing_out}, {1'b0, prev});
        wr(0, 3'd3, 8'h3F);
        wr(0, 3'd2, 8'h01);
        chk("R9", "locked writes ignored", timing_out, prev);
        rd(0, 3'd3, v, o);
        chk("R11", "locked offset 3 not owned", {o, v}, 9'h000);
        steps(0, 7, 7'h22);
        rd(0, 3'd3, v, o);
        chk("R11", "staging reloaded on unlock", {o, v}, {1'b1, 2'b00, prev});
        rd(0, 3'd5, v, o);

        // R10: arming read count sweep
        for (int n = 1; n <= 4; n++) begin
            wr(1, 3'd6, 8'h00);
            for (int i = 0; i < n; i++) rd(0, 3'd2, v, o);
            chk("R10", "armed after n reads", wide_armed, (n >= 3));
            rd(0, 3'd0, v, o);
            chk("R10", "data access keeps state", wide_armed, (n >= 3));
            wr(1, 3'd6, 8'h00);
            chk("R10", "other access clears", wide_armed, 0);
        end
        rd(0, 3'd2, v, o); rd(0, 3'd2, v, o);
        rd(0, 3'd0, v, o); rd(0, 3'd2, v, o);
        chk("R10", "broken run does not arm", wide_armed, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule